// File: doc/BRIEF.md
# Byte-to-Word IDE Bus Bridge

This block lets a host that can only issue 8-bit I/O cycles talk to a device whose data register is 16 bits wide. It claims a 16-byte I/O window (default base 0x300), turns each host request into a register access on the device side, and drives the device's 3-bit register address, two active-low chip selects and active-low read and write strobes. The device side is a synchronous register port: the bridge drives address, selects, strobes and write data from registers, and samples read data in the last cycle of a strobe.

A 16-bit word moves as two byte accesses in a fixed order. On reads, the host first reads the data register, which performs the whole word read and parks the upper byte in a read holding latch. It then reads the latch offset. On writes, the host first writes the upper byte to the latch offset, which only stores it. It then writes the data register, which sends the whole word. All other device registers pass through as plain byte transfers.

The host side uses a valid/ready handshake. The host raises `host_valid` with address, direction and write byte, and holds all of them steady until `host_ready` is seen high. `host_ready` is a one-cycle pulse that completes exactly one access, and `host_rdata` is valid in that cycle. The host may not start a new request in the cycle of the pulse. It may raise `host_valid` again from the following cycle.

Top module: `xt_ide_bridge`

## Requirements
- R1: While `rst_n` is low, `dev_rst_n` is low, both chip selects and both strobes are high (inactive), `host_ready` is low, and both holding latches are cleared to 0x00. The first latch read after reset returns 0x00. The first data write after reset sends 0x00 as the upper byte.
- R2: Host offset n (window base + n) maps as follows. For n in 0..7, `dev_cs0_n` is low with `dev_addr` = n. For offsets 0xE and 0xF, `dev_cs1_n` is low with `dev_addr` = 6 and 7 respectively. At most one chip select is low at any time, and a strobe is only ever low together with a chip select.
- R3: A host read of offset 0 performs one 16-bit device read. It returns `dev_rdata[7:0]` on `host_rdata` and stores `dev_rdata[15:8]` in the read holding latch.
- R4: A host read of offset 8 returns the read holding latch and causes no device strobe.
- R5: A host write of offset 8 stores `host_wdata` in the write holding latch and causes no device strobe.
- R6: A host write of offset 0 performs one 16-bit device write with `dev_wdata` = {write latch, `host_wdata`}.
- R7: Reads and writes of offsets 1..7, 0xE and 0xF are byte transfers on bits 7:0. A write drives `dev_wdata[15:8]` = 0x00. Neither holding latch changes.
- R8: Each device strobe stays low for exactly STROBE_CYC consecutive cycles (default 3). The address is stable throughout, and the two strobes are never low together. `host_ready` rises only after the strobe has returned high.
- R9: An access whose address lies outside the window, or at offsets 9..0xD, asserts no chip select or strobe. It completes with `host_rdata` = 0x00.
- R10: Each accepted request yields exactly one single-cycle `host_ready` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| host_valid | input | 1 | Host request valid, held until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host I/O address |
| host_wdata | input | 8 | Host write byte |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Read byte, valid with host_ready |
| dev_rst_n | output | 1 | Device reset, follows rst_n |
| dev_addr | output | 3 | Device register address |
| dev_cs0_n | output | 1 | Command-block select, active low |
| dev_cs1_n | output | 1 | Control-block select, active low |
| dev_rd_n | output | 1 | Device read strobe, active low |
| dev_wr_n | output | 1 | Device write strobe, active low |
| dev_wdata | output | 16 | Device write data |
| dev_rdata | input | 16 | Device read data |

## Verification
The bench sweeps every address from 0x2F0 to 0x31F with both a read and a write. Each device register holds a distinct 16-bit pattern, so an access routed to the wrong register, chip select or byte half shows up as a wrong value. After every write, all ten device registers are compared with a reference, which shows whether a latch or pass-through access touched anything it should not. The bench also counts strobe cycles per access, which separates accesses with no device access from 16-bit and byte transfers. Dedicated sequences after reset expose the cleared latches, and paired latch/data accesses with different bytes confirm the fixed byte order.

// File: rtl/ide_br_pkg.sv
package ide_br_pkg;
  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_DATA  = 3'd1,
    K_CMD   = 3'd2,
    K_CTL   = 3'd3,
    K_LATCH = 3'd4
  } acc_kind_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_XFER = 2'd1,
    S_DONE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/ide_br_decode.sv
module ide_br_decode
  import ide_br_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE = 10'h300
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_t         kind,
  output logic [2:0]        reg_sel
);
  logic       in_win;
  logic [3:0] off;

  assign in_win = (addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);
  assign off    = addr[3:0];

  always_comb begin
    kind    = K_NONE;
    reg_sel = 3'd0;
    if (in_win) begin
      if (off == 4'h0) begin
        kind = K_DATA;
      end else if (off < 4'h8) begin
        kind    = K_CMD;
        reg_sel = off[2:0];
      end else if (off == 4'h8) begin
        kind = K_LATCH;
      end else if (off >= 4'hE) begin
        kind    = K_CTL;
        reg_sel = {2'b11, off[0]};
      end
    end
  end
endmodule

// File: rtl/ide_br_latch.sv
module ide_br_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_en,
  input  logic [7:0] cap_val,
  input  logic       load_en,
  input  logic [7:0] load_val,
  output logic [7:0] rd_hi,
  output logic [7:0] wr_hi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hi <= 8'h00;
      wr_hi <= 8'h00;
    end else begin
      if (cap_en)  rd_hi <= cap_val;
      if (load_en) wr_hi <= load_val;
    end
  end
endmodule

// File: rtl/ide_br_timer.sv
module ide_br_timer #(
  parameter int STROBE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic last
);
  localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(STROBE_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (start) begin
      cnt    <= LOAD;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign last = active && (cnt == '0);
endmodule

// File: rtl/xt_ide_bridge.sv
module xt_ide_bridge
  import ide_br_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE = 10'h300,
  parameter int STROBE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic              host_ready,
  output logic [7:0]        host_rdata,
  output logic              dev_rst_n,
  output logic [2:0]        dev_addr,
  output logic              dev_cs0_n,
  output logic              dev_cs1_n,
  output logic              dev_rd_n,
  output logic              dev_wr_n,
  output logic [15:0]       dev_wdata,
  input  logic [15:0]       dev_rdata
);
  seq_state_t state;
  acc_kind_t  dec_kind, r_kind;
  logic [2:0] dec_reg, r_reg;
  logic       r_we;
  logic [7:0] r_wbyte, rdata_q;
  logic [7:0] rd_hi, wr_hi;
  logic       accept, dev_acc, t_last, in_xfer;
  logic       cap_en, load_en;

  ide_br_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr(host_addr), .kind(dec_kind), .reg_sel(dec_reg)
  );

  assign accept  = (state == S_IDLE) && host_valid;
  assign dev_acc = (dec_kind == K_DATA) || (dec_kind == K_CMD) || (dec_kind == K_CTL);
  assign in_xfer = (state == S_XFER);

  ide_br_timer #(.STROBE_CYC(STROBE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(accept && dev_acc), .last(t_last)
  );

  assign cap_en  = in_xfer && t_last && !r_we && (r_kind == K_DATA);
  assign load_en = accept && host_we && (dec_kind == K_LATCH);

  ide_br_latch u_lat (
    .clk(clk), .rst_n(rst_n),
    .cap_en(cap_en), .cap_val(dev_rdata[15:8]),
    .load_en(load_en), .load_val(host_wdata),
    .rd_hi(rd_hi), .wr_hi(wr_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      r_kind  <= K_NONE;
      r_reg   <= 3'd0;
      r_we    <= 1'b0;
      r_wbyte <= 8'h00;
      rdata_q <= 8'h00;
    end else begin
      case (state)
        S_IDLE: if (host_valid) begin
          r_kind  <= dec_kind;
          r_reg   <= dec_reg;
          r_we    <= host_we;
          r_wbyte <= host_wdata;
          if (dev_acc) begin
            state <= S_XFER;
          end else begin
            state   <= S_DONE;
            rdata_q <= (dec_kind == K_LATCH && !host_we) ? rd_hi : 8'h00;
          end
        end
        S_XFER: if (t_last) begin
          state   <= S_DONE;
          rdata_q <= r_we ? 8'h00 : dev_rdata[7:0];
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign host_ready = (state == S_DONE);
  assign host_rdata = host_ready ? rdata_q : 8'h00;
  assign dev_rst_n  = rst_n;
  assign dev_addr   = in_xfer ? r_reg : 3'd0;
  assign dev_cs0_n  = !(in_xfer && r_kind != K_CTL);
  assign dev_cs1_n  = !(in_xfer && r_kind == K_CTL);
  assign dev_rd_n   = !(in_xfer && !r_we);
  assign dev_wr_n   = !(in_xfer && r_we);
  assign dev_wdata  = !(in_xfer && r_we) ? 16'h0000 :
                      (r_kind == K_DATA) ? {wr_hi, r_wbyte} : {8'h00, r_wbyte};
endmodule

// File: rtl/ide_br_checker.sv
module ide_br_checker #(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE = 10'h300,
  parameter int STROBE_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_valid,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_ready,
  input logic [2:0]        dev_addr,
  input logic              dev_cs0_n,
  input logic              dev_cs1_n,
  input logic              dev_rd_n,
  input logic              dev_wr_n
);
  logic        strb;
  logic [15:0] wcnt;
  logic        outside;

  assign strb    = !dev_rd_n || !dev_wr_n;
  assign outside = host_addr[ADDR_W-1:4] != BASE[ADDR_W-1:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wcnt <= 16'd0;
    else if (strb) wcnt <= wcnt + 16'd1;
    else           wcnt <= 16'd0;
  end

  assert_one_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!dev_cs0_n, !dev_cs1_n}) && (!strb || !(dev_cs0_n && dev_cs1_n)));

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dev_rd_n && !dev_wr_n));

  assert_strobe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb && $past(strb)) |-> (wcnt == 16'(STROBE_CYC)));

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb |=> (!strb || $stable(dev_addr)));

  assert_ready_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> !strb);

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);

  assert_outside_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && outside) |-> (dev_cs0_n && dev_cs1_n && !strb));
endmodule

bind xt_ide_bridge ide_br_checker #(
  .ADDR_W(ADDR_W), .BASE(BASE), .STROBE_CYC(STROBE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_addr(host_addr),
  .host_ready(host_ready), .dev_addr(dev_addr), .dev_cs0_n(dev_cs0_n),
  .dev_cs1_n(dev_cs1_n), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n)
);

// File: tb/xt_ide_bridge_tb.sv
module xt_ide_bridge_tb;
  localparam int ADDR_W = 10;
  localparam logic [ADDR_W-1:0] BASE = 10'h300;
  localparam int N = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_valid = 1'b0, host_we = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [7:0] host_wdata = 8'h00;
  logic host_ready;
  logic [7:0] host_rdata;
  logic dev_rst_n, dev_cs0_n, dev_cs1_n, dev_rd_n, dev_wr_n;
  logic [2:0] dev_addr;
  logic [15:0] dev_wdata, dev_rdata;

  logic [15:0] dmem [0:9];
  logic [15:0] refm [0:9];
  logic [7:0]  e_rd_hi, e_wr_hi;
  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  xt_ide_bridge #(.ADDR_W(ADDR_W), .BASE(BASE), .STROBE_CYC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rdata(host_rdata), .dev_rst_n(dev_rst_n), .dev_addr(dev_addr),
    .dev_cs0_n(dev_cs0_n), .dev_cs1_n(dev_cs1_n), .dev_rd_n(dev_rd_n),
    .dev_wr_n(dev_wr_n), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  always_comb begin
    if (!dev_cs0_n)      dev_rdata = dmem[dev_addr];
    else if (!dev_cs1_n) dev_rdata = dmem[8 + int'(dev_addr[0])];
    else                 dev_rdata = 16'h0000;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  // One access; returns read byte and number of strobe-low cycles
  task automatic access(input logic we, input logic [ADDR_W-1:0] a,
                        input logic [7:0] wd, output logic [7:0] rd, output int ns);
    int guard = 0;
    ns = 0;
    host_valid = 1'b1; host_we = we; host_addr = a; host_wdata = wd;
    forever begin
      @(negedge clk);
      guard++;
      if (!dev_rd_n || !dev_wr_n) ns++;
      if (!dev_wr_n) begin
        if (!dev_cs0_n) dmem[dev_addr] = dev_wdata;
        else if (!dev_cs1_n) dmem[8 + int'(dev_addr[0])] = dev_wdata;
      end
      if (host_ready || guard > 20) break;
    end
    rd = host_rdata;
    host_valid = 1'b0;
    @(negedge clk);
    chk("R10 ready pulse", {31'd0, host_ready}, 32'd0);
  endtask

  task automatic cmp_mem(input string req);
    for (int i = 0; i < 10; i++) chk(req, {16'd0, dmem[i]}, {16'd0, refm[i]});
  endtask

  initial begin
    logic [7:0] rd;
    int ns;
    for (int i = 0; i < 10; i++) begin
      dmem[i] = 16'((i + 1) * 16'h1357);
      refm[i] = dmem[i];
    end
    e_rd_hi = 8'h00; e_wr_hi = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 dev_rst_n", {31'd0, dev_rst_n}, 32'd0);
    chk("R1 ready", {31'd0, host_ready}, 32'd0);
    chk("R1 strobes/cs", {28'd0, dev_rd_n, dev_wr_n, dev_cs0_n, dev_cs1_n}, 32'hF);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dev_rst_n release", {31'd0, dev_rst_n}, 32'd1);
    // R1 latches clear: latch read and data write before any load
    access(1'b0, BASE + 10'd8, 8'h00, rd, ns);
    chk("R1 read latch zero", {24'd0, rd}, 32'd0);
    chk("R4 no strobe", ns, 0);
    access(1'b1, BASE, 8'h77, rd, ns);
    refm[0] = 16'h0077;
    chk("R1 write latch zero", {16'd0, dmem[0]}, {16'd0, refm[0]});
    chk("R8 strobe width", ns, N);
    // R5/R6 ordered word write
    access(1'b1, BASE + 10'd8, 8'hAB, rd, ns);
    chk("R5 no strobe", ns, 0);
    e_wr_hi = 8'hAB;
    access(1'b1, BASE, 8'hCD, rd, ns);
    refm[0] = 16'hABCD;
    cmp_mem("R6 word write");
    // R3/R4 ordered word read
    dmem[0] = 16'h1234; refm[0] = 16'h1234;
    access(1'b0, BASE, 8'h00, rd, ns);
    chk("R3 low byte", {24'd0, rd}, 32'h34);
    chk("R3 strobe width R8", ns, N);
    access(1'b0, BASE + 10'd8, 8'h00, rd, ns);
    chk("R4 high byte", {24'd0, rd}, 32'h12);
    e_rd_hi = 8'h12;

    // Sweep: every address 0x2F0..0x31F, read then write
    for (int a = 10'h2F0; a < 10'h320; a++) begin
      logic [3:0] off;
      logic       win;
      logic [7:0] er, wv;
      int         en, idx;
      off = 4'(a);
      win = (a >= 10'h300) && (a < 10'h310);
      idx = -1;
      if (win && off < 4'h8) idx = int'(off);
      else if (win && off >= 4'hE) idx = 8 + int'(off[0]);
      // read
      if (idx >= 0) begin er = refm[idx][7:0]; en = N; end
      else if (win && off == 4'h8) begin er = e_rd_hi; en = 0; end
      else begin er = 8'h00; en = 0; end
      access(1'b0, ADDR_W'(a), 8'h00, rd, ns);
      if (win && off == 4'h0) begin
        chk("R3 sweep read", {24'd0, rd}, {24'd0, er});
        e_rd_hi = refm[0][15:8];
      end else if (idx >= 0) chk("R2 R7 sweep read", {24'd0, rd}, {24'd0, er});
      else if (win && off == 4'h8) chk("R4 sweep read", {24'd0, rd}, {24'd0, er});
      else chk("R9 sweep read", {24'd0, rd}, {24'd0, er});
      chk("R8 R9 sweep strobes", ns, en);
      // write
      wv = 8'(a * 37 + 5);
      if (win && off == 4'h0) refm[0] = {e_wr_hi, wv};
      else if (idx >= 0) refm[idx] = {8'h00, wv};
      else if (win && off == 4'h8) e_wr_hi = wv;
      access(1'b1, ADDR_W'(a), wv, rd, ns);
      chk("R5 R9 sweep write strobes", ns, (idx >= 0) ? N : 0);
      cmp_mem(win ? "R2 R6 R7 sweep mem" : "R9 sweep mem");
    end
    // R7: latches untouched by pass-through traffic
    access(1'b0, BASE + 10'd8, 8'h00, rd, ns);
    chk("R7 read latch kept", {24'd0, rd}, {24'd0, e_rd_hi});
    access(1'b1, BASE, 8'h5A, rd, ns);
    refm[0] = {e_wr_hi, 8'h5A};
    cmp_mem("R7 write latch kept");
    finish_run();
  end
endmodule